// File: doc/BRIEF.md
# Latched 4-to-16 Line Decoder

This block turns a 4-bit select code into one of sixteen active-high lines. Code 0 raises line 0 and code 15 raises line 15. Every other line stays low. A 4-bit code register sits in front of the decoder.

While the latch-enable input is high, the register reloads on every rising clock edge. In that state the lines also follow the select inputs directly, with no clock delay. When latch enable drops, the register keeps the code it took at the last rising edge. The selected line then stays high while the select inputs wander. Typical uses are holding an address decode or a routing choice steady.

A separate blanking input forces every line low. It does not touch the stored code, so the earlier selection comes back as soon as blanking is released. A synchronous reset clears the stored code to zero.

Top module: `latch_decoder`

## Requirements
- R1: With blanking low, select code n (bit 3 most significant, bit 0 least significant) drives output bit n high and all other output bits low, for every n from 0 to 15.
- R2: While latch enable is high and blanking is low, the output follows the select inputs in the same cycle, without waiting for a clock edge.
- R3: While latch enable is low, changes on the select inputs have no effect on the output.
- R4: While blanking is high, all sixteen output bits are low, whatever latch enable and the select inputs are.
- R5: Raising and then releasing blanking leaves the stored code unchanged, so the previous selection reappears. This holds in both the held and the transparent state.
- R6: A synchronous reset clears the stored code to 0. With latch enable low after reset, output bit 0 is high.
- R7: On every cycle the output has at most one bit set.
- R8: The stored code is the select value sampled at the last rising clock edge at which latch enable was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the code register loads on the rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the stored code |
| latchOpen | input | 1 | Latch enable: high = transparent and loading, low = hold |
| blankAll | input | 1 | High forces all outputs low |
| selCode | input | 4 | Select code |
| lineOut | output | 16 | Decoded lines, one-hot or all zero |

## Verification
The bench closes the latch in the same cycle that it changes the select inputs. This shows that the held code comes from the last edge with the latch open, not from the inputs at the moment it closed. A design that sampled the inputs late would show the new code.

The bench then moves the select inputs across several clocks while the latch is held. A design that loaded the register without checking latch enable would move the output.

The bench also blanks the outputs in both latch states and then releases blanking. A design that cleared or reloaded the register during blanking would bring back the wrong line.

Finally, it loads a non-zero code before reset and checks that reset alone returns the output to line 0. It also watches every cycle for more than one line set at once.

// File: rtl/ld_pkg.sv
package ld_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic loadCode;     // capture select inputs into the code register
    logic clearCode;    // synchronous clear of the code register
    logic passThrough;  // decode the live inputs instead of the register
    logic blank;        // force every line low
  } ldStrobe_t;
endpackage

// File: rtl/ld_ctrl.sv
module ld_ctrl
  import ld_pkg::*;
(
  input  logic       rst,
  input  logic       latchOpen,
  input  logic       blankAll,
  output ldStrobe_t  strobe
);
  always_comb begin
    strobe             = '0;
    strobe.clearCode   = rst;
    strobe.loadCode    = latchOpen && !rst;
    strobe.passThrough = latchOpen;
    strobe.blank       = blankAll;
  end
endmodule

// File: rtl/ld_datapath.sv
module ld_datapath
  import ld_pkg::*;
#(
  parameter int SEL_W = 4,
  localparam int OUT_W = 1 << SEL_W
) (
  input  logic             clk,
  input  ldStrobe_t        strobe,
  input  logic [SEL_W-1:0] selCode,
  output logic [OUT_W-1:0] lineOut
);
  logic [SEL_W-1:0] codeReg;
  logic [SEL_W-1:0] effCode;

  always_ff @(posedge clk) begin
    if (strobe.clearCode)
      codeReg <= '0;
    else if (strobe.loadCode)
      codeReg <= selCode;
  end

  always_comb effCode = strobe.passThrough ? selCode : codeReg;

  for (genvar g = 0; g < OUT_W; g++) begin : gLine
    assign lineOut[g] = !strobe.blank && (effCode == SEL_W'(g));
  end
endmodule

// File: rtl/latch_decoder.sv
module latch_decoder
  import ld_pkg::*;
#(
  parameter int SEL_W = 4,
  localparam int OUT_W = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             latchOpen,
  input  logic             blankAll,
  input  logic [SEL_W-1:0] selCode,
  output logic [OUT_W-1:0] lineOut
);
  ldStrobe_t strobe;

  ld_ctrl ctrl (
    .rst(rst), .latchOpen(latchOpen), .blankAll(blankAll), .strobe(strobe)
  );

  ld_datapath #(.SEL_W(SEL_W)) dp (
    .clk(clk), .strobe(strobe), .selCode(selCode), .lineOut(lineOut)
  );
endmodule

// File: rtl/latch_decoder_chk.sv
module latch_decoder_chk #(
  parameter int SEL_W = 4,
  localparam int OUT_W = 1 << SEL_W
) (
  input logic             clk,
  input logic             rst,
  input logic             latchOpen,
  input logic             blankAll,
  input logic [SEL_W-1:0] selCode,
  input logic [OUT_W-1:0] lineOut
);
  AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (rst)
    blankAll |-> (lineOut == '0)); // R4

  AST_ONEHOT_OR_ZERO: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lineOut)); // R7

  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!latchOpen && !blankAll && !$past(latchOpen) && !$past(blankAll) && !$past(rst))
      |-> $stable(lineOut)); // R3

  AST_LAST_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!latchOpen && !blankAll && $past(latchOpen) && !$past(rst))
      |-> lineOut[$past(selCode)]); // R8

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !latchOpen && !blankAll) |-> (lineOut == OUT_W'(1))); // R6
endmodule

bind latch_decoder latch_decoder_chk #(.SEL_W(SEL_W)) chkInst (
  .clk(clk), .rst(rst), .latchOpen(latchOpen), .blankAll(blankAll),
  .selCode(selCode), .lineOut(lineOut)
);

// File: tb/latch_decoder_test.sv
module latch_decoder_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        latchOpen;
  logic        blankAll;
  logic [3:0]  selCode;
  logic [15:0] lineOut;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  latch_decoder uut (
    .clk(clk), .rst(rst), .latchOpen(latchOpen), .blankAll(blankAll),
    .selCode(selCode), .lineOut(lineOut)
  );

  task automatic check(input string tag, input logic [15:0] exp);
    checks++;
    if (lineOut !== exp) begin
      errors++;
      $display("FAIL %s: lineOut=%h expected=%h", tag, lineOut, exp);
    end
  endtask

  // R7: at most one line on every cycle, sampled mid-cycle
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if ($countones(lineOut) > 1) begin
        errors++;
        $display("FAIL R7: lineOut=%h expected=onehot0", lineOut);
      end
    end
  end

  // inputs change on the falling edge; results read 1 ns later
  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic testReset();
    latchOpen = 1'b1; selCode = 4'd9; cycle();
    latchOpen = 1'b0; #1 check("R8 load before reset", 16'h0200);
    rst = 1'b1; cycle();
    rst = 1'b0; selCode = 4'd5; #1 check("R6 reset clears code", 16'h0001);
  endtask

  task automatic testTransparent();
    latchOpen = 1'b1;
    for (int i = 0; i < 16; i++) begin
      selCode = 4'(i);
      #1 check($sformatf("R1 R2 code %0d", i), 16'(1) << i);
      cycle();
    end
  endtask

  task automatic testHold();
    latchOpen = 1'b1; selCode = 4'd6; cycle();
    latchOpen = 1'b0; selCode = 4'd11;
    #1 check("R3 hold after close", 16'h0040);
    for (int i = 0; i < 4; i++) begin
      selCode = 4'(i * 5 + 1); cycle();
      #1 check("R3 select ignored while held", 16'h0040);
    end
  endtask

  task automatic testLastEdge();
    latchOpen = 1'b1; selCode = 4'd3; cycle();
    latchOpen = 1'b0; selCode = 4'd12;
    #1 check("R8 code from last open edge", 16'h0008);
    cycle();
    #1 check("R8 still held", 16'h0008);
  endtask

  task automatic testBlank();
    // held state: stored code 3
    blankAll = 1'b1; #1 check("R4 blank held", 16'h0000);
    selCode = 4'd14; cycle();
    #1 check("R4 blank held after clock", 16'h0000);
    blankAll = 1'b0; #1 check("R5 held code returns", 16'h0008);
    // transparent state
    latchOpen = 1'b1; selCode = 4'd13; cycle();
    blankAll = 1'b1; #1 check("R4 blank transparent", 16'h0000);
    latchOpen = 1'b0; cycle();
    #1 check("R4 blank after close", 16'h0000);
    blankAll = 1'b0; #1 check("R5 stored code kept", 16'h2000);
    latchOpen = 1'b1; #1 check("R2 reopen", 16'h2000);
    latchOpen = 1'b0; cycle();
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: lineOut=%h expected=completion", lineOut);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; latchOpen = 1'b0; blankAll = 1'b0; selCode = 4'd0;
    @(negedge clk); cycle();
    rst = 1'b0; #1 check("R6 reset state", 16'h0001);
    @(negedge clk);
    testReset();
    testTransparent();
    testHold();
    testLastEdge();
    testBlank();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule